// File: doc/BRIEF.md
# Indexed bit and shift operation sequencer

This block executes the double-prefixed indexed bit group of an 8-bit processor once the prefix pair has been recognised elsewhere. On a start request it captures the program counter, the incoming flags and one of two 16-bit index registers. It then walks the byte stream through a simple memory port. First it fetches a signed displacement. Next it reads the operand byte at the index plus that displacement. Only after that does it fetch the opcode byte that says what to do with the operand.

The opcode selects a rotate or shift, a bit test, a bit clear or a bit set. Modifying operations write the new byte back to the same address. The block finishes with a one-cycle done pulse that carries the new flags, the program counter advanced by two, and the cycle cost of the instruction. The memory port returns read data combinationally while the read strobe is high. The surrounding core owns the register file and commits the outputs when done is seen.

Top module: `idx_bitop_seq`

## Requirements
- R1: After reset the block is idle. busy, done, mem_rd and mem_wr are low, and cycles_out is 0.
- R2: A run makes exactly three reads, in this order: the displacement at the start PC, the operand at the effective address, then the opcode at start PC+1. At done, pc_out equals start PC+2.
- R3: The effective address is the index register plus the sign-extended displacement, modulo 2^16. The index is idx_b when use_alt is 1 and idx_a otherwise.
- R4: Opcode 00kkk110 applies shift kind k to the operand and writes it back: 0 rotate left circular, 1 rotate right circular, 2 rotate left through carry, 3 rotate right through carry, 4 shift left arithmetic, 5 shift right arithmetic, 6 shift left inserting 1, 7 shift right logical. The bit shifted out goes to carry (flag bit 0). The cost is 23.
- R5: The flag byte uses S=bit7, Z=bit6, H=bit4, P=bit2, N=bit1 and C=bit0; bits 5 and 3 pass through unchanged. After a rotate or shift, S copies result bit 7, Z is set for a zero result, P is set for even parity, and H and N are cleared.
- R6: Opcode 01bbbrrr, for any rrr, tests operand bit b. Z is set when that bit is 0, H is set, N is cleared, and all other flags are preserved. Memory is not written, and the cost is 20.
- R7: Opcode 10bbb110 clears operand bit b, and 11bbb110 sets it. Either result is written back, the flags are unchanged, and the cost is 23.
- R8: Any opcode in the rotate, clear or set classes whose low three bits are not 110 is a no-op. There is no write, the flags are unchanged, and the cost is 15.
- R9: Any write goes to the address of the operand read, three cycles after that read. done is a single-cycle pulse: it follows the write by one cycle, or follows the execute step when there is no write.
- R10: start is ignored while busy. busy rises only in the cycle after an idle start.
- R11: mem_rd and mem_wr are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin a run; used only while idle |
| use_alt | input | 1 | Pick idx_b instead of idx_a as the base |
| idx_a | input | 16 | First index register value |
| idx_b | input | 16 | Second index register value |
| pc_in | input | 16 | Address of the displacement byte |
| flags_in | input | 8 | Flags before the instruction |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid while mem_rd is high |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle completion pulse |
| flags_out | output | 8 | Resulting flags, valid at done |
| pc_out | output | 16 | Advanced program counter, valid at done |
| cycles_out | output | 5 | Cycle cost of the instruction, valid at done |

## Verification
The assertions check, on every cycle, the properties that hold whatever the data is. The two strobes are never high together. Every write lands on the address that was read three cycles before. done is a lone pulse, and its reported cost agrees with whether a write preceded it. busy only begins after a start. The directed scenarios are the only way to show that data is correct: the shifted and bit-modified bytes, every flag bit, the effective address with sign extension and 16-bit wrap, the choice of index, the read order, and that unhandled opcodes leave both memory and flags untouched.

// File: rtl/idx_bitop_seq.sv
module idx_bitop_seq #(
  parameter int CW       = 5,
  parameter int CYC_ROT  = 23,
  parameter int CYC_TEST = 20,
  parameter int CYC_MOD  = 23,
  parameter int CYC_NOP  = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          use_alt,
  input  logic [15:0]   idx_a,
  input  logic [15:0]   idx_b,
  input  logic [15:0]   pc_in,
  input  logic [7:0]    flags_in,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic [15:0]   mem_addr,
  output logic [7:0]    mem_wdata,
  input  logic [7:0]    mem_rdata,
  output logic          busy,
  output logic          done,
  output logic [7:0]    flags_out,
  output logic [15:0]   pc_out,
  output logic [CW-1:0] cycles_out
);
  typedef enum logic [2:0] {S_IDLE, S_DISP, S_OPER, S_OPC, S_EXEC, S_WB, S_FIN} st_t;

  st_t          st;
  logic [15:0]  pc_r, ea;
  logic [7:0]   opnd, opc, fl, res;
  logic [CW-1:0] cyc;

  wire [1:0] cls      = opc[7:6];
  wire [2:0] sel      = opc[5:3];
  wire       mem_form = (opc[2:0] == 3'b110);
  wire [7:0] bmask    = 8'b1 << sel;

  logic [7:0] rot_r;
  logic       rot_c;
  always_comb begin
    unique case (sel)
      3'd0: begin rot_r = {opnd[6:0], opnd[7]}; rot_c = opnd[7]; end
      3'd1: begin rot_r = {opnd[0], opnd[7:1]}; rot_c = opnd[0]; end
      3'd2: begin rot_r = {opnd[6:0], fl[0]};   rot_c = opnd[7]; end
      3'd3: begin rot_r = {fl[0], opnd[7:1]};   rot_c = opnd[0]; end
      3'd4: begin rot_r = {opnd[6:0], 1'b0};    rot_c = opnd[7]; end
      3'd5: begin rot_r = {opnd[7], opnd[7:1]}; rot_c = opnd[0]; end
      3'd6: begin rot_r = {opnd[6:0], 1'b1};    rot_c = opnd[7]; end
      default: begin rot_r = {1'b0, opnd[7:1]}; rot_c = opnd[0]; end
    endcase
  end

  logic [7:0]    nfl, nres;
  logic          nwr;
  logic [CW-1:0] ncyc;
  always_comb begin
    nfl  = fl;
    nres = opnd;
    nwr  = 1'b0;
    ncyc = CW'(CYC_NOP);
    unique case (cls)
      2'b00: if (mem_form) begin
        nres = rot_r;
        nfl  = {rot_r[7], rot_r == 8'h00, fl[5], 1'b0, fl[3], ~^rot_r, 1'b0, rot_c};
        nwr  = 1'b1;
        ncyc = CW'(CYC_ROT);
      end
      2'b01: begin
        nfl[6] = ~opnd[sel];
        nfl[4] = 1'b1;
        nfl[1] = 1'b0;
        ncyc   = CW'(CYC_TEST);
      end
      2'b10: if (mem_form) begin
        nres = opnd & ~bmask;
        nwr  = 1'b1;
        ncyc = CW'(CYC_MOD);
      end
      default: if (mem_form) begin
        nres = opnd | bmask;
        nwr  = 1'b1;
        ncyc = CW'(CYC_MOD);
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      pc_r <= '0;
      ea   <= '0;
      opnd <= '0;
      opc  <= '0;
      fl   <= '0;
      res  <= '0;
      cyc  <= '0;
    end else begin
      unique case (st)
        S_IDLE: if (start) begin
          pc_r <= pc_in;
          ea   <= use_alt ? idx_b : idx_a;
          fl   <= flags_in;
          st   <= S_DISP;
        end
        S_DISP: begin
          ea   <= ea + {{8{mem_rdata[7]}}, mem_rdata};
          pc_r <= pc_r + 16'd1;
          st   <= S_OPER;
        end
        S_OPER: begin
          opnd <= mem_rdata;
          st   <= S_OPC;
        end
        S_OPC: begin
          opc  <= mem_rdata;
          pc_r <= pc_r + 16'd1;
          st   <= S_EXEC;
        end
        S_EXEC: begin
          fl  <= nfl;
          res <= nres;
          cyc <= ncyc;
          st  <= nwr ? S_WB : S_FIN;
        end
        S_WB:    st <= S_FIN;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign mem_rd     = (st == S_DISP) || (st == S_OPER) || (st == S_OPC);
  assign mem_wr     = (st == S_WB);
  assign mem_addr   = (st == S_OPER || st == S_WB) ? ea : pc_r;
  assign mem_wdata  = res;
  assign busy       = (st != S_IDLE);
  assign done       = (st == S_FIN);
  assign flags_out  = fl;
  assign pc_out     = pc_r;
  assign cycles_out = cyc;
endmodule

// File: rtl/idx_bitop_seq_chk.sv
module idx_bitop_seq_chk #(
  parameter int CW       = 5,
  parameter int CYC_ROT  = 23,
  parameter int CYC_TEST = 20,
  parameter int CYC_MOD  = 23,
  parameter int CYC_NOP  = 15
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          mem_rd,
  input logic          mem_wr,
  input logic [15:0]   mem_addr,
  input logic          busy,
  input logic          done,
  input logic [CW-1:0] cycles_out
);
  always_comb begin
    if (rst_n !== 1'b1)
      assert_reset_quiet_R1: assert (!mem_wr || rst_n === 1'b1);
  end

  assert_no_rdwr_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

  assert_wr_same_addr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> ($past(mem_rd, 3) && mem_addr == $past(mem_addr, 3)));

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));

  assert_done_after_wr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |=> done);

  assert_test_no_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && cycles_out == CW'(CYC_TEST)) |-> !$past(mem_wr));

  assert_nop_no_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && cycles_out == CW'(CYC_NOP)) |-> !$past(mem_wr));

  assert_cost_known_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cycles_out == CW'(CYC_ROT) || cycles_out == CW'(CYC_MOD) ||
              cycles_out == CW'(CYC_TEST) || cycles_out == CW'(CYC_NOP)));

  assert_busy_from_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));
endmodule

bind idx_bitop_seq idx_bitop_seq_chk #(
  .CW(CW), .CYC_ROT(CYC_ROT), .CYC_TEST(CYC_TEST), .CYC_MOD(CYC_MOD), .CYC_NOP(CYC_NOP)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .mem_rd(mem_rd), .mem_wr(mem_wr),
  .mem_addr(mem_addr), .busy(busy), .done(done), .cycles_out(cycles_out)
);

// File: tb/idx_bitop_seq_bench.sv
module idx_bitop_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        use_alt = 1'b0;
  logic [15:0] idx_a = '0, idx_b = '0, pc_in = '0;
  logic [7:0]  flags_in = '0;
  logic        mem_rd, mem_wr, busy, done;
  logic [15:0] mem_addr, pc_out;
  logic [7:0]  mem_wdata, mem_rdata, flags_out;
  logic [4:0]  cycles_out;

  logic [7:0]  mem [256];
  assign mem_rdata = mem[mem_addr[7:0]];

  idx_bitop_seq u_idx_bitop_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .use_alt(use_alt),
    .idx_a(idx_a), .idx_b(idx_b), .pc_in(pc_in), .flags_in(flags_in),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .busy(busy), .done(done), .flags_out(flags_out),
    .pc_out(pc_out), .cycles_out(cycles_out)
  );

  always #4 clk = ~clk;

  int n_checks = 0;
  int n_fails  = 0;
  int nrd, nwr;
  logic [15:0] rd_addr [4];
  logic [15:0] wr_addr;
  logic [7:0]  wr_data;

  always @(negedge clk) begin
    if (mem_rd) begin
      if (nrd < 4) rd_addr[nrd] = mem_addr;
      nrd = nrd + 1;
    end
    if (mem_wr) begin
      wr_addr = mem_addr;
      wr_data = mem_wdata;
      mem[mem_addr[7:0]] = mem_wdata;
      nwr = nwr + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic run(input logic [15:0] pc, input logic [15:0] ia, input logic [15:0] ib,
                     input bit alt, input logic [7:0] disp, input logic [7:0] opc,
                     input logic [7:0] opnd, input logic [7:0] fin, output logic [15:0] ea);
    ea = (alt ? ib : ia) + {{8{disp[7]}}, disp};
    mem[pc[7:0]] = disp;
    mem[8'(pc[7:0] + 8'd1)] = opc;
    mem[ea[7:0]] = opnd;
    nrd = 0; nwr = 0;
    pc_in = pc; idx_a = ia; idx_b = ib; use_alt = alt; flags_in = fin;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    while (!done) @(negedge clk);
  endtask

  task automatic check_run(input string req, input logic [15:0] pc, input logic [15:0] ea,
                           input logic [7:0] exp_mem, input logic [7:0] exp_fl,
                           input int exp_cyc, input int exp_wr);
    chk(nrd == 3, req, "read count", nrd, 3);
    chk(rd_addr[0] == pc && rd_addr[1] == ea && rd_addr[2] == pc + 16'd1, "R2",
        "operand address", rd_addr[1], ea);
    chk(pc_out == pc + 16'd2, "R2", "pc_out", pc_out, pc + 16'd2);
    chk(flags_out == exp_fl, req, "flags", flags_out, exp_fl);
    chk(cycles_out == 5'(exp_cyc), req, "cycles", cycles_out, exp_cyc);
    chk(nwr == exp_wr, req, "write count", nwr, exp_wr);
    chk(mem[ea[7:0]] == exp_mem, req, "memory byte", mem[ea[7:0]], exp_mem);
    if (exp_wr == 1) chk(wr_addr == ea, "R9", "write address", wr_addr, ea);
  endtask

  function automatic logic [8:0] rot_exp(input logic [2:0] k, input logic [7:0] v, input logic c);
    case (k)
      3'd0: return {v[7], v[6:0], v[7]};
      3'd1: return {v[0], v[0], v[7:1]};
      3'd2: return {v[7], v[6:0], c};
      3'd3: return {v[0], c, v[7:1]};
      3'd4: return {v[7], v[6:0], 1'b0};
      3'd5: return {v[0], v[7], v[7:1]};
      3'd6: return {v[7], v[6:0], 1'b1};
      default: return {v[0], 1'b0, v[7:1]};
    endcase
  endfunction

  task automatic t_reset;
    chk(!busy && !done && !mem_rd && !mem_wr, "R1", "idle strobes", {busy, done, mem_rd, mem_wr}, 0);
    chk(cycles_out == 0, "R1", "cycles after reset", cycles_out, 0);
  endtask

  task automatic t_rotates;
    logic [7:0] vals [3] = '{8'h81, 8'h00, 8'h5A};
    logic [15:0] ea;
    for (int k = 0; k < 8; k++) begin
      for (int j = 0; j < 3; j++) begin
        logic [7:0] fin;
        logic [8:0] e;
        logic [7:0] ef;
        fin = (j == 2) ? 8'hFF : 8'h28;
        e  = rot_exp(3'(k), vals[j], fin[0]);
        ef = {e[7], e[7:0] == 8'h00, fin[5], 1'b0, fin[3], ~^e[7:0], 1'b0, e[8]};
        run(16'h0040, 16'h0080, 16'h0000, 1'b0, 8'h05, {2'b00, 3'(k), 3'b110}, vals[j], fin, ea);
        check_run("R4", 16'h0040, ea, e[7:0], ef, 23, 1);
        chk(flags_out == ef, "R5", "rotate flags", flags_out, ef);
      end
    end
  endtask

  task automatic t_bittest;
    logic [15:0] ea;
    for (int b = 0; b < 8; b++) begin
      logic [7:0] v, fin, ef;
      v   = 8'hA5;
      fin = (b % 2 == 0) ? 8'h01 : 8'hEC;
      ef  = fin;
      ef[6] = ~v[b];
      ef[4] = 1'b1;
      ef[1] = 1'b0;
      run(16'h0010, 16'h0000, 16'h00A0, 1'b1, 8'h07, {2'b01, 3'(b), 3'(b)}, v, fin, ea);
      check_run("R6", 16'h0010, ea, v, ef, 20, 0);
    end
  endtask

  task automatic t_resset;
    logic [15:0] ea;
    for (int b = 0; b < 8; b++) begin
      logic [7:0] m;
      m = 8'h01 << b;
      run(16'h0020, 16'h0090, 16'h0000, 1'b0, 8'hFE, {2'b10, 3'(b), 3'b110}, 8'hFF, 8'h53, ea);
      check_run("R7", 16'h0020, ea, 8'hFF & ~m, 8'h53, 23, 1);
      run(16'h0020, 16'h0090, 16'h0000, 1'b0, 8'hFE, {2'b11, 3'(b), 3'b110}, 8'h00, 8'hAC, ea);
      check_run("R7", 16'h0020, ea, m, 8'hAC, 23, 1);
    end
  endtask

  task automatic t_noop;
    logic [7:0] ops [4] = '{8'h00, 8'h07, 8'h85, 8'hFF};
    logic [15:0] ea;
    foreach (ops[i]) begin
      run(16'h0030, 16'h00C0, 16'h0000, 1'b0, 8'h01, ops[i], 8'h3C, 8'h97, ea);
      check_run("R8", 16'h0030, ea, 8'h3C, 8'h97, 15, 0);
    end
  endtask

  task automatic t_ea;
    logic [15:0] ea;
    run(16'h0050, 16'h1234, 16'hFFF0, 1'b1, 8'h20, 8'hC6, 8'h00, 8'h00, ea);
    chk(ea == 16'h0010, "R3", "bench wrap address", ea, 16'h0010);
    check_run("R3", 16'h0050, 16'h0010, 8'h01, 8'h00, 23, 1);
    run(16'h0050, 16'h0180, 16'hFFFF, 1'b0, 8'h90, 8'hC6, 8'h00, 8'h00, ea);
    check_run("R3", 16'h0050, 16'h0110, 8'h01, 8'h00, 23, 1);
  endtask

  task automatic t_busy;
    logic [15:0] ea;
    ea = 16'h0070 + 16'h0004;
    mem[8'h60] = 8'h04; mem[8'h61] = 8'hC6; mem[8'h74] = 8'h00;
    nrd = 0; nwr = 0;
    pc_in = 16'h0060; idx_a = 16'h0070; use_alt = 1'b0; flags_in = 8'h00;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    @(negedge clk); pc_in = 16'h0099; start = 1'b1;
    @(negedge clk); start = 1'b0;
    while (!done) @(negedge clk);
    chk(pc_out == 16'h0062, "R10", "pc_out with restart attempt", pc_out, 16'h0062);
    chk(nrd == 3, "R10", "reads with restart attempt", nrd, 3);
    repeat (3) @(negedge clk);
    chk(!busy, "R10", "idle after done", busy, 0);
    chk(mem[8'h74] == 8'h01, "R10", "result", mem[8'h74], 8'h01);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    nrd = 0; nwr = 0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_rotates();
    t_bittest();
    t_resset();
    t_noop();
    t_ea();
    t_busy();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule